// File: doc/BRIEF.md
# Asynchronous Host Memory Port

This block lets a microprocessor read and write any word of a 1024-entry, 24-bit accumulator memory at random. The host's read and write strobes are not related to the core clock. Each strobe goes through a two-flop synchroniser. The synchronised falling edge starts exactly one memory access in the core domain. The memory array is outside the block. The port drives a single-cycle request with a write-enable, address and write data, and it takes the read word back one cycle after a read request.

The host data bus is modelled as separate input, output and output-enable vectors. The bus is 24 bits wide, or 16 bits wide when `bus_narrow` is high. In narrow mode, `upper_sel` picks the half of the word that the host sees. When `upper_sel` is high, the top 8 bits of the word are carried on bus lanes 7..0. When it is low, the bottom 16 bits are carried on lanes 15..0. A narrow write changes only the selected half. It does this with a read followed by a write of the merged word. A completed read is held on `bus_o` until the next read completes. `bus_oe` tracks the read strobe directly, so the host sees the bus float as soon as it releases the strobe. Strobes count only while `async_mode` is high.

Top module: `host_mem_port`

## Requirements
- R1: `bus_oe` is high exactly while `async_mode` is high and `host_rd_n` is low, and low at all other times.
- R2: In wide mode (`bus_narrow`=0), a read loads all 24 bits of the addressed word into `bus_o`. This happens on the fifth rising clock edge after `host_rd_n` is sampled low, and `upper_sel` has no effect.
- R3: In narrow mode, a read with `upper_sel`=1 puts word bits 23..16 on `bus_o` bits 7..0 with bits 23..8 zero. A read with `upper_sel`=0 puts word bits 15..0 on `bus_o` bits 15..0 with bits 23..16 zero.
- R4: In wide mode, a write stores `bus_i[23:0]` at the captured address whatever the value of `upper_sel`.
- R5: A narrow write with `upper_sel`=1 stores `bus_i[7:0]` into word bits 23..16 and leaves bits 15..0 unchanged.
- R6: A narrow write with `upper_sel`=0 stores `bus_i[15:0]` into word bits 15..0 and leaves bits 23..16 unchanged.
- R7: While `async_mode` is low, strobe edges cause no memory request and do not change `bus_o`.
- R8: `bus_o` keeps the last read result while the read strobe stays low, even if the memory word changes. It changes only when a later read completes.
- R9: Each synchronised strobe fall causes exactly one access. That is one request for a read or a wide write, and a read then a write to the same address two cycles apart for a narrow write. Address, data, width and half-select are sampled when the synchronised fall is seen, so the host keeps them stable while the strobe is low.
- R10: After reset, `bus_o` is zero and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| async_mode | input | 1 | High when host access mode is selected |
| bus_narrow | input | 1 | 1 selects the 16-bit bus, 0 the 24-bit bus |
| upper_sel | input | 1 | Narrow mode half select, 1 = bits 23..16 |
| host_addr | input | 10 | Host word address |
| host_rd_n | input | 1 | Active-low read strobe, asynchronous |
| host_wr_n | input | 1 | Active-low write strobe, asynchronous |
| bus_i | input | 24 | Data driven by the host onto the bus |
| bus_o | output | 24 | Data the port drives onto the bus |
| bus_oe | output | 1 | Bus driver enable; bus floats when low |
| mem_req | output | 1 | Single-cycle memory access request |
| mem_we | output | 1 | Write enable qualifying `mem_req` |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, valid one cycle after a read request |

## Verification
Reads and writes are run at the lowest address, the highest address and a spread of computed addresses in between. Each write is read back in wide mode and in both narrow halves, which separates a wrong lane mapping from a wrong merge. Narrow writes to the two halves of the same word show whether the read-modify-write keeps the half that was not selected. A wide write with `upper_sel` high shows that the select is ignored in wide mode. Strobes issued with `async_mode` low, and a memory word altered while the read strobe is held low, show whether anything reaches memory or the bus when it should not.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUED,
        ST_RD_CAPTURE,
        ST_RMW_ISSUED,
        ST_RMW_CAPTURE
    } seq_state_e;

endpackage

// File: rtl/hmp_strobe_sync.sv
module hmp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], strobe_n};
        end else begin : g_single
            always_comb chain_d = strobe_n;
        end
    endgenerate

    always_comb begin
        prev_d = chain_q[LAST];
        fall   = prev_q & ~chain_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R9

endmodule

// File: rtl/hmp_lane_steer.sv
module hmp_lane_steer #(
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic                narrow,
    input  logic                upper,
    input  logic [WORD_W-1:0]   mem_word,
    input  logic [NARROW_W-1:0] host_half,
    output logic [WORD_W-1:0]   rd_fmt,
    output logic [WORD_W-1:0]   wr_merge
);
    localparam int UPPER_W = WORD_W - NARROW_W;

    logic [WORD_W-1:0] up_rd, lo_rd, up_wr, lo_wr;

    always_comb begin
        up_rd = {{NARROW_W{1'b0}}, mem_word[WORD_W-1 -: UPPER_W]};
        lo_rd = {{UPPER_W{1'b0}}, mem_word[NARROW_W-1:0]};
        up_wr = {host_half[UPPER_W-1:0], mem_word[NARROW_W-1:0]};
        lo_wr = {mem_word[WORD_W-1 -: UPPER_W], host_half};

        if (!narrow) begin
            rd_fmt   = mem_word;
            wr_merge = mem_word;
        end else if (upper) begin
            rd_fmt   = up_rd;
            wr_merge = up_wr;
        end else begin
            rd_fmt   = lo_rd;
            wr_merge = lo_wr;
        end
    end

endmodule

// File: rtl/hmp_access_seq.sv
module hmp_access_seq
    import hmp_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                async_mode,
    input  logic                bus_narrow,
    input  logic                upper_sel,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [WORD_W-1:0]   bus_i,
    input  logic                rd_fall,
    input  logic                wr_fall,
    input  logic [WORD_W-1:0]   rd_fmt,
    input  logic [WORD_W-1:0]   wr_merge,
    output logic                narrow_q,
    output logic                upper_q,
    output logic [NARROW_W-1:0] host_half_q,
    output logic [WORD_W-1:0]   hold_q,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata
);
    typedef struct packed {
        seq_state_e          st;
        logic                req;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   wdata;
        logic [WORD_W-1:0]   hold;
        logic [NARROW_W-1:0] host;
        logic                narrow;
        logic                upper;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        r_d.we  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (async_mode && wr_fall) begin
                    r_d.addr   = host_addr;
                    r_d.narrow = bus_narrow;
                    r_d.upper  = upper_sel;
                    r_d.host   = bus_i[NARROW_W-1:0];
                    r_d.req    = 1'b1;
                    if (bus_narrow) begin
                        r_d.st = ST_RMW_ISSUED;
                    end else begin
                        r_d.we    = 1'b1;
                        r_d.wdata = bus_i;
                    end
                end else if (async_mode && rd_fall) begin
                    r_d.addr   = host_addr;
                    r_d.narrow = bus_narrow;
                    r_d.upper  = upper_sel;
                    r_d.req    = 1'b1;
                    r_d.st     = ST_RD_ISSUED;
                end
            end
            ST_RD_ISSUED:   r_d.st = ST_RD_CAPTURE;
            ST_RD_CAPTURE: begin
                r_d.hold = rd_fmt;
                r_d.st   = ST_IDLE;
            end
            ST_RMW_ISSUED:  r_d.st = ST_RMW_CAPTURE;
            ST_RMW_CAPTURE: begin
                r_d.req   = 1'b1;
                r_d.we    = 1'b1;
                r_d.wdata = wr_merge;
                r_d.st    = ST_IDLE;
            end
            default:        r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        narrow_q    = r_q.narrow;
        upper_q     = r_q.upper;
        host_half_q = r_q.host;
        hold_q      = r_q.hold;
        mem_req     = r_q.req;
        mem_we      = r_q.we;
        mem_addr    = r_q.addr;
        mem_wdata   = r_q.wdata;
    end

    AST_RD_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && !r_q.we) |=> !r_q.req); // R9

    AST_RMW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && r_q.we && r_q.narrow) |->
            ($past(r_q.req, 2) && !$past(r_q.we, 2) && ($past(r_q.addr, 2) == r_q.addr))); // R9

    AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) && !async_mode) |=> !r_q.req); // R7

    AST_HOLD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.hold) |-> ($past(r_q.st) == ST_RD_CAPTURE)); // R8

endmodule

// File: rtl/host_mem_port.sv
module host_mem_port #(
    parameter int ADDR_W      = 10,
    parameter int WORD_W      = 24,
    parameter int NARROW_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              async_mode,
    input  logic              bus_narrow,
    input  logic              upper_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [WORD_W-1:0] bus_i,
    output logic [WORD_W-1:0] bus_o,
    output logic              bus_oe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic                rd_fall, wr_fall;
    logic                narrow_q, upper_q;
    logic [NARROW_W-1:0] host_half_q;
    logic [WORD_W-1:0]   rd_fmt, wr_merge, hold_q;

    hmp_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_rd_n), .fall(rd_fall));

    hmp_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n), .fall(wr_fall));

    hmp_lane_steer #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_steer (
        .narrow(narrow_q), .upper(upper_q), .mem_word(mem_rdata),
        .host_half(host_half_q), .rd_fmt(rd_fmt), .wr_merge(wr_merge));

    hmp_access_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .async_mode(async_mode),
        .bus_narrow(bus_narrow), .upper_sel(upper_sel), .host_addr(host_addr),
        .bus_i(bus_i), .rd_fall(rd_fall), .wr_fall(wr_fall),
        .rd_fmt(rd_fmt), .wr_merge(wr_merge),
        .narrow_q(narrow_q), .upper_q(upper_q), .host_half_q(host_half_q),
        .hold_q(hold_q), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata));

    always_comb begin
        bus_o  = hold_q;
        bus_oe = async_mode & ~host_rd_n;
    end

endmodule

// File: tb/tb_host_mem_port.sv
module tb_host_mem_port;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        async_mode = 1'b1;
    logic        bus_narrow = 1'b0;
    logic        upper_sel = 1'b0;
    logic [9:0]  host_addr = '0;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [23:0] bus_i = '0;
    logic [23:0] bus_o;
    logic        bus_oe;
    logic        mem_req, mem_we;
    logic [9:0]  mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;

    logic [23:0] ram     [DEPTH];
    logic [23:0] ref_mem [DEPTH];

    int checks = 0;
    int errors = 0;
    int req_count = 0;
    int exp_reqs = 0;
    bit exp_oe = 1'b0;
    logic [23:0] exp_bus = '0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_mem_port dut (
        .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .bus_narrow(bus_narrow),
        .upper_sel(upper_sel), .host_addr(host_addr), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    // behavioural model of the external array
    always @(posedge clk) begin
        if (rst_n && mem_req) begin
            req_count <= req_count + 1;
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] view(input logic [23:0] w, input bit nar, input bit up);
        if (!nar) return w;
        if (up)   return (w >> 16) & 24'h0000FF;
        return w & 24'h00FFFF;
    endfunction

    function automatic logic [23:0] merge(input logic [23:0] old, input logic [23:0] d,
                                          input bit nar, input bit up);
        if (!nar) return d;
        if (up)   return (old & 24'h00FFFF) | ((d & 24'h0000FF) << 16);
        return (old & 24'hFF0000) | (d & 24'h00FFFF);
    endfunction

    // per-clock comparison against the reference model
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !finished) begin
            check(bus_oe == exp_oe, "R1 bus_oe", {31'b0, bus_oe}, {31'b0, exp_oe});
            check(bus_o == exp_bus, "R8 bus_o", {8'b0, bus_o}, {8'b0, exp_bus});
        end
    end

    task automatic host_read(input logic [9:0] a, input bit nar, input bit up,
                             input int linger, input string tag);
        logic [23:0] v;
        @(negedge clk);
        host_addr = a; bus_narrow = nar; upper_sel = up; host_rd_n = 1'b0;
        exp_oe = async_mode;
        if (async_mode) exp_reqs++;
        repeat (5) @(posedge clk);
        if (async_mode) exp_bus = view(ref_mem[a], nar, up);
        v = exp_bus;
        #(CLK_PERIOD/4);
        check(bus_o == v, tag, {8'b0, bus_o}, {8'b0, v});
        repeat (linger) @(negedge clk);
        host_rd_n = 1'b1; exp_oe = 1'b0;
        repeat (4) @(negedge clk);
        check(req_count == exp_reqs, "R9 read request count", req_count, exp_reqs);
    endtask

    task automatic host_write(input logic [9:0] a, input logic [23:0] d, input bit nar,
                              input bit up, input string tag);
        @(negedge clk);
        host_addr = a; bus_narrow = nar; upper_sel = up; bus_i = d; host_wr_n = 1'b0;
        if (async_mode) begin
            ref_mem[a] = merge(ref_mem[a], d, nar, up);
            exp_reqs += nar ? 2 : 1;
        end
        repeat (8) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        check(ram[a] == ref_mem[a], tag, {8'b0, ram[a]}, {8'b0, ref_mem[a]});
        check(req_count == exp_reqs, "R9 write request count", req_count, exp_reqs);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ram[i]     = 24'(i * 24'h01F3A7 + 24'h5A5A5A);
            ref_mem[i] = ram[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_o == 24'h0, "R10 bus_o after reset", {8'b0, bus_o}, 32'h0);
        check(mem_req == 1'b0, "R10 mem_req after reset", {31'b0, mem_req}, 32'h0);

        // R2: wide reads, upper_sel ignored
        host_read(10'd5, 1'b0, 1'b0, 2, "R2 wide read");
        host_read(10'd6, 1'b0, 1'b1, 2, "R2 wide read upper_sel high");

        // R4: wide write with upper_sel set
        host_write(10'd10, 24'hC3A581, 1'b0, 1'b1, "R4 wide write");
        host_read(10'd10, 1'b0, 1'b0, 1, "R4 wide readback");

        // R5 / R6: narrow halves on the same word
        host_write(10'd20, 24'h7777EE, 1'b1, 1'b1, "R5 narrow upper write");
        host_write(10'd20, 24'h99B4D2, 1'b1, 1'b0, "R6 narrow lower write");
        host_read(10'd20, 1'b0, 1'b0, 1, "R5 R6 merged word readback");
        host_read(10'd20, 1'b1, 1'b1, 1, "R3 narrow upper read");
        host_read(10'd20, 1'b1, 1'b0, 1, "R3 narrow lower read");

        // R7: strobes ignored outside host mode
        @(negedge clk); async_mode = 1'b0;
        host_write(10'd30, 24'h123456, 1'b0, 1'b0, "R7 write ignored");
        host_read(10'd31, 1'b0, 1'b0, 2, "R7 read ignored, bus unchanged");
        @(negedge clk); async_mode = 1'b1;
        host_read(10'd30, 1'b0, 1'b0, 1, "R7 word untouched");

        // R8: hold while strobe low, memory changes underneath
        @(negedge clk);
        host_addr = 10'd40; bus_narrow = 1'b0; upper_sel = 1'b0; host_rd_n = 1'b0;
        exp_oe = 1'b1; exp_reqs++;
        repeat (5) @(posedge clk);
        exp_bus = ref_mem[40];
        @(negedge clk);
        ram[40] = 24'hFFFFFF; ref_mem[40] = 24'hFFFFFF;
        repeat (6) @(negedge clk);
        check(bus_o == exp_bus, "R8 held during strobe", {8'b0, bus_o}, {8'b0, exp_bus});
        host_rd_n = 1'b1; exp_oe = 1'b0;
        repeat (4) @(negedge clk);

        // boundary addresses
        host_write(10'd1023, 24'hABCDEF, 1'b1, 1'b1, "R5 top address narrow upper");
        host_read(10'd1023, 1'b0, 1'b0, 1, "R2 top address readback");
        host_write(10'd0, 24'h0F0F0F, 1'b1, 1'b0, "R6 address zero narrow lower");
        host_read(10'd0, 1'b1, 1'b0, 1, "R3 address zero lower read");

        // spread of computed accesses
        for (int k = 0; k < 12; k++) begin
            logic [9:0]  a;
            logic [23:0] d;
            a = 10'((k * 97 + 13) % DEPTH);
            d = 24'(k * 24'h3C1B5 + 24'h0A0B0C);
            host_write(a, d, k[0], k[1], "R4 R5 R6 sweep write");
            host_read(a, k[1], k[0], 1, "R2 R3 sweep read");
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule